// File: doc/BRIEF.md
# Single-Bit Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM that stores 65536 one-bit words, with separate data-in and data-out pins. The host issues one request at a time through a valid/ready handshake. A request carries a 16-bit address, a write flag and one write bit. For a read, the block returns a single response bit together with a one-cycle valid pulse. On the memory side the block drives registered address and data-in lines and two active-low strobes: one selects the chip and the other enables a write. It also samples the memory's data-out pin.

Every phase of an access lasts a whole number of clock cycles. Each count is derived at elaboration time from the clock period and the memory's nanosecond limits. The memory performs a write only while both strobes are low. The block therefore ends a write by raising write enable first and releasing chip select one cycle later. Address and data stay where they are until a hold margin has elapsed. A read keeps chip select low for the longer of the address access time and the select access time. The data-out pin is sampled on the edge that releases the chip. Successive accesses start no closer together than the memory's cycle time.

Top module: `sram_x1_ctrl`

## Requirements
- R1: During and directly after reset, chip select and write enable are high, `rsp_valid` is low and `req_ready` is high.
- R2: Write enable is low only while chip select is also low. During a read, write enable stays high for the whole access.
- R3: A write drives chip select and write enable low on the edge that accepts the request. Write enable then stays low for exactly WR = max of the rounded-up counts for pulse width, address-to-end, select-to-end and data setup, which is 2 cycles with the defaults.
- R4: Chip select rises exactly one cycle after write enable rises, so a write holds chip select low for WR+1 cycles.
- R5: A read holds chip select low for exactly RD = max(address access, select access) cycles, which is 2 with the defaults. The data-out pin is sampled on the edge where chip select rises. `rsp_valid` is high for exactly one cycle directly after that edge, and `rsp_rdata` carries the sampled bit. Each read produces exactly one response.
- R6: Address and data-in change only on the edge that accepts a request. They stay stable through the access and through the HOLD = max(address hold, data hold) cycles after chip select rises, which is 1 cycle with the defaults.
- R7: `req_ready` is low from the accepting edge until the access and its hold have ended, and never fewer than CYC cycles, where CYC is the rounded-up cycle time. With the defaults, a write keeps ready low for max(WR+1+HOLD, CYC) = 4 cycles and a read keeps it low for max(RD+HOLD, CYC) = 3 cycles.
- R8: Each count equals its nanosecond limit divided by the clock period and rounded up, with a minimum of one cycle.
- R9: Every address from 0 to 65535 is driven as given, and a bit written to any address reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 1 | Read bit |
| mem_addr | output | 16 | Memory address lines |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_din | output | 1 | Memory data-in line |
| mem_dout | input | 1 | Memory data-out line |

## Verification
The hardest situation to reach from the ports is the narrow gap between two accesses. Here a new request must wait both for the hold margin after chip select rises and for the cycle-time guard. The strobe order at the end of a write must also be correct, because the memory commits the bit only when the overlap ends. The driver therefore keeps requests back to back: each one is presented on the first cycle ready returns. The bench counts cycles of write-enable-low, chip-select-low and ready-low for each access. A bench memory model stores a bit only when the overlap of the two strobes closes. Reads of alternating patterns at both ends of the address range then expose any mis-ordered strobe or misplaced sample.

// File: rtl/sram_x1_pkg.sv
package sram_x1_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LOW,
    ST_WR_END,
    ST_RD_WAIT,
    ST_HOLD
  } seq_state_t;

  // rounded-up cycle count of a nanosecond limit, never below one
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_x1_phase_timer.sv
module sram_x1_phase_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_x1_spacing.sv
module sram_x1_spacing #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic open_o
);

  localparam int SP_W = $clog2(CYC + 1);

  logic [SP_W-1:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= SP_W'(CYC);
    end else if (start) begin
      since <= SP_W'(1);
    end else if (since < SP_W'(CYC)) begin
      since <= since + 1'b1;
    end
  end

  assign open_o = (since >= SP_W'(CYC));

endmodule

// File: rtl/sram_x1_ctrl.sv
module sram_x1_ctrl
  import sram_x1_pkg::*;
#(
  parameter int ADDR_W           = 16,
  parameter int CLK_PERIOD_NS    = 20,
  parameter int T_CYCLE_NS       = 35,
  parameter int T_WE_PULSE_NS    = 30,
  parameter int T_ADDR_TO_END_NS = 35,
  parameter int T_CS_TO_END_NS   = 35,
  parameter int T_DIN_SETUP_NS   = 22,
  parameter int T_DIN_HOLD_NS    = 3,
  parameter int T_ADDR_HOLD_NS   = 5,
  parameter int T_ADDR_ACC_NS    = 35,
  parameter int T_CS_ACC_NS      = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_din,
  input  logic              mem_dout
);

  localparam int WR_CYC = max2(
      max2(ns_to_cycles(T_WE_PULSE_NS, CLK_PERIOD_NS),
           ns_to_cycles(T_ADDR_TO_END_NS, CLK_PERIOD_NS)),
      max2(ns_to_cycles(T_CS_TO_END_NS, CLK_PERIOD_NS),
           ns_to_cycles(T_DIN_SETUP_NS, CLK_PERIOD_NS)));
  localparam int RD_CYC = max2(ns_to_cycles(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                               ns_to_cycles(T_CS_ACC_NS, CLK_PERIOD_NS));
  localparam int HOLD_CYC = max2(ns_to_cycles(T_ADDR_HOLD_NS, CLK_PERIOD_NS),
                                 ns_to_cycles(T_DIN_HOLD_NS, CLK_PERIOD_NS));
  localparam int CYC_CYC = ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int TMR_MAX = max2(max2(WR_CYC, RD_CYC), HOLD_CYC);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  seq_state_t       state;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             spacing_open;

  // named internal events
  logic accept;
  logic write_end;
  logic read_sample;
  logic hold_done;

  assign req_ready   = (state == ST_IDLE) && spacing_open;
  assign accept      = req_valid && req_ready;
  assign write_end   = (state == ST_WR_LOW) && tmr_expired;
  assign read_sample = (state == ST_RD_WAIT) && tmr_expired;
  assign hold_done   = (state == ST_HOLD) && tmr_expired;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = req_write ? TMR_W'(WR_CYC - 1) : TMR_W'(RD_CYC - 1);
    end else if ((state == ST_WR_END) || read_sample) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(HOLD_CYC - 1);
    end
  end

  sram_x1_phase_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_x1_spacing #(.CYC(CYC_CYC)) u_spacing (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .open_o (spacing_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_addr  <= '0;
      mem_din   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            mem_addr <= req_addr;
            mem_cs_n <= 1'b0;
            if (req_write) begin
              mem_din  <= req_wdata;
              mem_we_n <= 1'b0;
              state    <= ST_WR_LOW;
            end else begin
              state    <= ST_RD_WAIT;
            end
          end
        end
        ST_WR_LOW: begin
          if (write_end) begin
            mem_we_n <= 1'b1;
            state    <= ST_WR_END;
          end
        end
        ST_WR_END: begin
          mem_cs_n <= 1'b1;
          state    <= ST_HOLD;
        end
        ST_RD_WAIT: begin
          if (read_sample) begin
            rsp_rdata <= mem_dout;
            rsp_valid <= 1'b1;
            mem_cs_n  <= 1'b1;
            state     <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (hold_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_x1_ctrl_chk.sv
module sram_x1_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int WR_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              accept,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_din
);

  int wl_cnt;

  always_ff @(posedge clk) begin
    if (rst) wl_cnt <= 0;
    else if (!mem_we_n) wl_cnt <= wl_cnt + 1;
    else wl_cnt <= 0;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_we_n && !rsp_valid));

  a_r2_we_inside_cs: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_cs_n);

  a_r3_write_len: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (wl_cnt == WR_CYC));

  a_r4_cs_after_we: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_cs_n ##1 mem_cs_n));

  a_r5_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r6_lines_stable: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(mem_addr) && $stable(mem_din)));

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> !req_ready);

endmodule

bind sram_x1_ctrl sram_x1_ctrl_chk #(.ADDR_W(ADDR_W), .WR_CYC(WR_CYC)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .accept    (accept),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_din   (mem_din)
);

// File: tb/test_sram_x1_ctrl.sv
module test_sram_x1_ctrl;

  localparam int PER = 20;
  localparam int NS_CYCLE = 35, NS_WP = 30, NS_AW = 35, NS_CW = 35, NS_DS = 22;
  localparam int NS_DH = 3, NS_AH = 5, NS_AA = 35, NS_ACS = 35;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_din;
  logic        mem_dout = 1'b0;

  int compared = 0, mismatched = 0;
  bit dev_mem [int unsigned];
  bit ref_mem [int unsigned];
  bit exp_q [$];
  bit was_act = 1'b0;
  int wa = 0;
  bit wd = 1'b0;

  always #(PER/2) clk = ~clk;

  sram_x1_ctrl #(
    .CLK_PERIOD_NS(PER), .T_CYCLE_NS(NS_CYCLE), .T_WE_PULSE_NS(NS_WP),
    .T_ADDR_TO_END_NS(NS_AW), .T_CS_TO_END_NS(NS_CW), .T_DIN_SETUP_NS(NS_DS),
    .T_DIN_HOLD_NS(NS_DH), .T_ADDR_HOLD_NS(NS_AH), .T_ADDR_ACC_NS(NS_AA),
    .T_CS_ACC_NS(NS_ACS)
  ) i_sram_x1_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_din(mem_din),
    .mem_dout(mem_dout)
  );

  // R8: bench's own rounding, by counting up periods
  function automatic int cyc_of(input int ns);
    int n = 1;
    while (n * PER < ns) n++;
    return n;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int EXP_WR, EXP_RD, EXP_HOLD, EXP_CYC;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model: commits a bit only when the strobe overlap closes
  always @(negedge clk) begin
    bit act;
    act = !mem_cs_n && !mem_we_n;
    if (was_act && !act) dev_mem[wa] = wd;
    was_act = act;
    wa = int'(mem_addr);
    wd = mem_din;
    if (!mem_cs_n && mem_we_n)
      mem_dout <= dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 1'b0;
    else
      mem_dout <= 1'b0;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "response with none pending", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R5 R9", "read data", int'(rsp_rdata), int'(e));
      end
    end
  end

  task automatic do_write(input int a, input bit d);
    int i = 0, we_lo = 0, cs_lo = 0;
    bit stable_ok = 1'b1, order_ok = 1'b1;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a[15:0]; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    while (!req_ready && i < 1000) begin
      if (!mem_we_n) we_lo++;
      if (!mem_cs_n) cs_lo++;
      if (!mem_we_n && mem_cs_n) order_ok = 1'b0;
      if (mem_addr !== a[15:0] || mem_din !== d) stable_ok = 1'b0;
      i++;
      @(negedge clk);
    end
    chk(we_lo == EXP_WR, "R3 R8", "write-enable low cycles", we_lo, EXP_WR);
    chk(cs_lo == EXP_WR + 1, "R4", "select low cycles on write", cs_lo, EXP_WR + 1);
    chk(order_ok, "R2", "write enable low outside select", 0, 1);
    chk(stable_ok, "R6", "address/data stable on write", 0, 1);
    chk(i == mx(EXP_WR + 1 + EXP_HOLD, EXP_CYC), "R7", "write busy cycles",
        i, mx(EXP_WR + 1 + EXP_HOLD, EXP_CYC));
    ref_mem[a] = d;
  endtask

  task automatic do_read(input int a);
    int i = 0, we_lo = 0, cs_lo = 0, rsp_at = -1;
    bit stable_ok = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : 1'b0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a[15:0];
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && i < 1000) begin
      if (!mem_we_n) we_lo++;
      if (!mem_cs_n) cs_lo++;
      if (rsp_valid && rsp_at < 0) rsp_at = i;
      if (mem_addr !== a[15:0]) stable_ok = 1'b0;
      i++;
      @(negedge clk);
    end
    if (rsp_valid && rsp_at < 0) rsp_at = i;
    chk(we_lo == 0, "R2", "write enable low during read", we_lo, 0);
    chk(cs_lo == EXP_RD, "R5 R8", "select low cycles on read", cs_lo, EXP_RD);
    chk(rsp_at == EXP_RD, "R5", "response cycle", rsp_at, EXP_RD);
    chk(stable_ok, "R6", "address stable on read", 0, 1);
    chk(i == mx(EXP_RD + EXP_HOLD, EXP_CYC), "R7", "read busy cycles",
        i, mx(EXP_RD + EXP_HOLD, EXP_CYC));
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    EXP_WR   = mx(mx(cyc_of(NS_WP), cyc_of(NS_AW)), mx(cyc_of(NS_CW), cyc_of(NS_DS)));
    EXP_RD   = mx(cyc_of(NS_AA), cyc_of(NS_ACS));
    EXP_HOLD = mx(cyc_of(NS_AH), cyc_of(NS_DH));
    EXP_CYC  = cyc_of(NS_CYCLE);

    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n, "R1", "strobes in reset", {mem_cs_n, mem_we_n}, 3);
    chk(!rsp_valid, "R1", "response in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && mem_we_n, "R1", "strobes after reset", {mem_cs_n, mem_we_n}, 3);
    chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);

    // address range ends and a middle pair, R9
    do_write(0, 1'b1);
    do_write(16'hFFFF, 1'b1);
    do_write(16'h1234, 1'b0);
    do_write(16'h8000, 1'b1);
    do_read(0);
    do_read(16'hFFFF);
    do_read(16'h1234);
    do_read(16'h8000);
    do_read(16'h7FFF);
    // overwrite then read back
    do_write(0, 1'b0);
    do_read(0);
    do_write(16'hFFFF, 1'b0);
    do_read(16'hFFFF);
    // scattered pattern, interleaved read/write
    for (int k = 0; k < 24; k++) do_write((k * 40503 + 7) & 16'hFFFF, k[0] ^ k[2]);
    for (int k = 23; k >= 0; k--) do_read((k * 40503 + 7) & 16'hFFFF);
    for (int k = 0; k < 8; k++) begin
      do_write(k << 13, ~k[0]);
      do_read(k << 13);
    end

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "responses outstanding", exp_q.size(), 0);
    finish_run();
  end

endmodule